// File: doc/BRIEF.md
# Eight-bit multiply and divide unit

This unit performs the two wide arithmetic operations of a small eight-bit processor on its accumulator pair. Multiply forms the unsigned 16-bit product of the Y and A operands and returns the high byte in Y and the low byte in A. Divide takes the 16-bit value formed by Y (high) and A (low), divides it by the eight-bit X operand, and returns the quotient in A and the remainder in Y.

Divide does not trap on overflow. When the high byte Y is at least twice X, the quotient would not fit in nine bits, and the unit instead produces a defined wrapped result computed from 256 − X. The same path covers X = 0. The V and H flags of a divide come from comparisons of the operands as they stood before the operation. N and Z always describe the result.

The caller raises a one-cycle start strobe with an operation select and the three operands. Multiply completes in one clock. Divide runs a bit-serial restoring divider and takes 2·W + 2 clocks. A one-cycle done pulse marks the completion of either operation. Results and flags are registered and hold their values until the next completion.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is high, and after it is released, `a_out`, `y_out`, all four flags and `done` are zero until the first operation completes.
- R2: With `op` = 0 (multiply), an accepted start yields {`y_out`,`a_out`} = `y_in` × `a_in` as an unsigned 16-bit product, with `done` high in the cycle right after the start edge.
- R3: After multiply, `flag_n` equals bit 15 of the product and `flag_z` is set only when all 16 bits of the product are zero. `flag_v` and `flag_h` keep their previous values.
- R4: With `op` = 1 (divide) and `y_in` < 2·`x_in`, `a_out` = ({Y,A} / X) mod 256 and `y_out` = ({Y,A} mod X) mod 256.
- R5: With `op` = 1 and `y_in` ≥ 2·`x_in`, `a_out` = (255 − ({Y,A} − 512·X) / (256 − X)) mod 256 and `y_out` = (X + ({Y,A} − 512·X) mod (256 − X)) mod 256.
- R6: A divide with `x_in` = 0 always takes the R5 path with a divisor of 256 and gives a defined result.
- R7: After divide, `flag_v` is set exactly when `y_in` ≥ `x_in`, and `flag_h` is set exactly when `y_in[3:0]` ≥ `x_in[3:0]`. Both comparisons use the operands sampled with the start.
- R8: After divide, `flag_n` equals bit 7 of the 8-bit quotient and `flag_z` is set only when that quotient is zero.
- R9: A divide raises `done` 2·W + 2 clocks after its start edge (18 clocks for W = 8), counting the start edge as the first. `done` lasts exactly one cycle.
- R10: A start strobe raised while a divide is in progress is ignored. It yields no extra `done`, and the divide's results are those of the first operands.
- R11: Outputs and flags stay stable in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the unit is idle |
| op | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | W | A operand (low byte of dividend, multiplicand) |
| x_in | input | W | X operand (divisor) |
| y_in | input | W | Y operand (high byte of dividend, multiplier) |
| a_out | output | W | A result: product low byte or quotient |
| y_out | output | W | Y result: product high byte or remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_h | output | 1 | Half-carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the boundaries of the wrapped-quotient path. These are X = 0, where the divisor becomes 256, and Y exactly equal to 2·X, where the path switches from ordinary division. Neither case shows up in ordinary operand patterns. The stimulus sweeps all 256 divisor values against a set of dividends that includes 0x0000, 0xFFFF and values with Y at and near 2·X, and checks each result against an arithmetic model of both formulas. A separate scenario strobes start repeatedly during a running divide, to show that the strobe is ignored.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_e;
endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   lhs,
  input  logic [W-1:0]   rhs,
  output logic [2*W-1:0] prod
);
  always_comb prod = (2*W)'(lhs) * (2*W)'(rhs);
endmodule

// File: rtl/muldiv_divcore.sv
// Bit-serial restoring divider: one quotient bit per clock, NW clocks.
module muldiv_divcore #(
  parameter int NW = 16,
  parameter int DW = 9,
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [QW-1:0] quo,
  output logic [DW-2:0] rem,
  output logic          busy,
  output logic          fin
);
  localparam int CW = (NW > 1) ? $clog2(NW) : 1;

  logic [NW-1:0] dvd_q;
  logic [DW-1:0] dvs_q;
  logic [DW-2:0] rem_q;
  logic [QW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] trial;
  logic [DW-1:0] diff;
  logic          qbit;

  always_comb begin
    trial = {rem_q, dvd_q[NW-1]};
    qbit  = (trial >= dvs_q);
    diff  = trial - dvs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q <= '0;
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        dvd_q <= num;
        dvs_q <= den;
        rem_q <= '0;
        quo_q <= '0;
        cnt_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        dvd_q <= {dvd_q[NW-2:0], 1'b0};
        quo_q <= {quo_q[QW-2:0], qbit};
        rem_q <= qbit ? diff[DW-2:0] : trial[DW-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/muldiv_divfix.sv
// Maps the raw quotient/remainder of the wrapped path back to the result.
module muldiv_divfix #(
  parameter int W = 8
) (
  input  logic [W-1:0] q_raw,
  input  logic [W-1:0] r_raw,
  input  logic [W-1:0] x,
  input  logic         wide,
  output logic [W-1:0] q,
  output logic [W-1:0] r
);
  always_comb begin
    if (wide) begin
      q = {W{1'b1}} - q_raw;
      r = x + r_raw;
    end else begin
      q = q_raw;
      r = r_raw;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] y_out,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_h,
  output logic         done
);
  import muldiv_pkg::*;

  localparam int PW = 2 * W;
  localparam int DW = W + 1;
  localparam int NB = W / 2;

  op_e           op_sel;
  logic          busy;
  logic          accept;
  logic [PW-1:0] prod;
  logic [PW-1:0] ya;
  logic          wide;
  logic [PW-1:0] num;
  logic [DW-1:0] den;
  logic [W-1:0]  quo;
  logic [W-1:0]  rem;
  logic          core_busy;
  logic          core_fin;
  logic [W-1:0]  x_q;
  logic          wide_q;
  logic          v_q;
  logic          h_q;
  logic [W-1:0]  q_fix;
  logic [W-1:0]  r_fix;

  always_comb begin
    op_sel = op_e'(op);
    busy   = core_busy | core_fin;
    accept = start && !busy;
    ya     = {y_in, a_in};
    wide   = ({1'b0, y_in} >= {x_in, 1'b0});
    num    = wide ? (ya - (PW'(x_in) << (W + 1))) : ya;
    den    = wide ? ((DW'(1) << W) - DW'(x_in)) : DW'(x_in);
  end

  muldiv_mult #(.W(W)) u_mul (
    .lhs  (y_in),
    .rhs  (a_in),
    .prod (prod)
  );

  muldiv_divcore #(.NW(PW), .DW(DW), .QW(W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (accept && (op_sel == OP_DIV)),
    .num  (num),
    .den  (den),
    .quo  (quo),
    .rem  (rem),
    .busy (core_busy),
    .fin  (core_fin)
  );

  muldiv_divfix #(.W(W)) u_fix (
    .q_raw (quo),
    .r_raw (rem),
    .x     (x_q),
    .wide  (wide_q),
    .q     (q_fix),
    .r     (r_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out  <= '0;
      y_out  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_h <= 1'b0;
      done   <= 1'b0;
      x_q    <= '0;
      wide_q <= 1'b0;
      v_q    <= 1'b0;
      h_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept && (op_sel == OP_MUL)) begin
        {y_out, a_out} <= prod;
        flag_n <= prod[PW-1];
        flag_z <= (prod == '0);
        done   <= 1'b1;
      end else if (accept) begin
        x_q    <= x_in;
        wide_q <= wide;
        v_q    <= (y_in >= x_in);
        h_q    <= (y_in[NB-1:0] >= x_in[NB-1:0]);
      end
      if (core_fin) begin
        a_out  <= q_fix;
        y_out  <= r_fix;
        flag_n <= q_fix[W-1];
        flag_z <= (q_fix == '0);
        flag_v <= v_q;
        flag_h <= h_q;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         op,
  input logic [W-1:0] a_in,
  input logic [W-1:0] y_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] y_out,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_h,
  input logic         done,
  input logic         busy
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && a_out == '0 && y_out == '0 &&
                    !flag_n && !flag_z && !flag_v && !flag_h));

  p_mul_product_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !op && !busy) |->
      (done && {y_out, a_out} == ((2*W)'($past(y_in)) * (2*W)'($past(a_in)))));

  p_mul_nz_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !op && !busy) |->
      (flag_n == y_out[W-1] && flag_z == ({y_out, a_out} == '0)));

  p_mul_keeps_vh_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !op && !busy) |-> ($stable(flag_v) && $stable(flag_h)));

  p_quiet_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(a_out) && $stable(y_out) && $stable(flag_n) &&
               $stable(flag_z) && $stable(flag_v) && $stable(flag_h)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .a_in   (a_in),
  .y_in   (y_in),
  .a_out  (a_out),
  .y_out  (y_out),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .flag_v (flag_v),
  .flag_h (flag_h),
  .done   (done),
  .busy   (busy)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic [W-1:0] a_out;
  logic [W-1:0] y_out;
  logic         flag_n;
  logic         flag_z;
  logic         flag_v;
  logic         flag_h;
  logic         done;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .a_in(a_in), .x_in(x_in), .y_in(y_in),
    .a_out(a_out), .y_out(y_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_h(flag_h),
    .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic void ref_div(input int y, input int a, input int x,
                                  output int q, output int r);
    int ya;
    ya = y * 256 + a;
    if (y < 2 * x) begin
      q = (ya / x) & 255;
      r = (ya % x) & 255;
    end else begin
      q = (255 - (ya - 512 * x) / (256 - x)) & 255;
      r = (x + (ya - 512 * x) % (256 - x)) & 255;
    end
  endfunction

  task automatic run_op(input logic opv, input int a, input int x, input int y,
                        output int lat);
    @(negedge clk);
    op = opv; a_in = W'(a); x_in = W'(x); y_in = W'(y); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_div(input int a, input int x, input int y, input string tag);
    int lat, q, r;
    run_op(1'b1, a, x, y, lat);
    ref_div(y, a, x, q, r);
    chk({tag, " quotient"}, int'(a_out), q);
    chk({tag, " remainder"}, int'(y_out), r);
    chk("R7 V flag", int'(flag_v), int'(y >= x));
    chk("R7 H flag", int'(flag_h), int'((y & 15) >= (x & 15)));
    chk("R8 N flag", int'(flag_n), (q >> 7) & 1);
    chk("R8 Z flag", int'(flag_z), int'(q == 0));
  endtask

  task automatic t_reset;
    chk("R1 a_out", int'(a_out), 0);
    chk("R1 y_out", int'(y_out), 0);
    chk("R1 flags", int'({flag_n, flag_z, flag_v, flag_h}), 0);
    chk("R1 done", int'(done), 0);
  endtask

  task automatic t_mul;
    int lat;
    int pairs[6][2] = '{'{0, 0}, '{1, 1}, '{8'h12, 8'h34}, '{8'hFF, 8'hFF},
                        '{8'h80, 8'h01}, '{0, 8'hA5}};
    foreach (pairs[i]) begin
      int p;
      run_op(1'b0, pairs[i][1], 8'h33, pairs[i][0], lat);
      p = pairs[i][0] * pairs[i][1];
      chk("R2 latency", lat, 1);
      chk("R2 product", int'({y_out, a_out}), p);
      chk("R3 N flag", int'(flag_n), (p >> 15) & 1);
      chk("R3 Z flag", int'(flag_z), int'(p == 0));
      @(posedge clk); @(negedge clk);
      chk("R9 done single cycle", int'(done), 0);
    end
  endtask

  task automatic t_div_normal;
    check_div(8'h34, 8'h56, 8'h12, "R4");
    check_div(8'hFF, 8'h01, 8'h00, "R4");
    check_div(8'h00, 8'h80, 8'hFF, "R4");
    check_div(8'h05, 8'h07, 8'h0D, "R4");
  endtask

  task automatic t_div_wide;
    check_div(8'h00, 8'h10, 8'h40, "R5");
    check_div(8'hFF, 8'h01, 8'hFF, "R5");
    check_div(8'h00, 8'h7F, 8'hFE, "R5");
    check_div(8'h12, 8'h20, 8'h40, "R5");
  endtask

  task automatic t_div_zero;
    check_div(8'h00, 8'h00, 8'h00, "R6");
    check_div(8'hFF, 8'h00, 8'hFF, "R6");
    check_div(8'h34, 8'h00, 8'h12, "R6");
  endtask

  task automatic t_latency;
    int lat;
    run_op(1'b1, 8'h10, 8'h03, 8'h01, lat);
    chk("R9 divide latency", lat, 2 * W + 2);
    @(posedge clk); @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
  endtask

  task automatic t_busy_ignore;
    int lat, q, r, dones;
    @(negedge clk);
    op = 1'b1; a_in = 8'h00; x_in = 8'h10; y_in = 8'h40; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op = 1'b0; a_in = 8'hFF; x_in = 8'h01; y_in = 8'hFF;
    lat = 1;
    dones = 0;
    for (int k = 0; k < 30; k++) begin
      if (k == 5) start = 1'b0;
      if (done) begin
        dones++;
        if (dones == 1) begin
          ref_div(8'h40, 8'h00, 8'h10, q, r);
          chk("R10 first-operand quotient", int'(a_out), q);
          chk("R10 first-operand remainder", int'(y_out), r);
          chk("R10 latency unchanged", lat, 2 * W + 2);
        end
      end
      @(posedge clk); @(negedge clk);
      if (dones == 0) lat++;
    end
    chk("R10 single done", dones, 1);
    ref_div(8'h40, 8'h00, 8'h10, q, r);
    chk("R11 quotient held", int'(a_out), q);
    chk("R11 remainder held", int'(y_out), r);
  endtask

  task automatic t_vh_hold;
    int lat;
    check_div(8'h00, 8'h11, 8'h33, "R4");
    run_op(1'b0, 8'h02, 8'h00, 8'h03, lat);
    chk("R3 V kept set", int'(flag_v), 1);
    chk("R3 H kept set", int'(flag_h), 1);
    check_div(8'h00, 8'h3F, 8'h20, "R4");
    run_op(1'b0, 8'h02, 8'h00, 8'h03, lat);
    chk("R3 V kept clear", int'(flag_v), 0);
    chk("R3 H kept clear", int'(flag_h), 0);
  endtask

  task automatic t_sweep;
    int yas[10] = '{16'h0000, 16'h0001, 16'h00FF, 16'h1234, 16'h7F80,
                    16'h8000, 16'hFE01, 16'hFFFF, 16'h0100, 16'h4321};
    foreach (yas[i]) begin
      for (int x = 0; x < 256; x++) begin
        int lat, q, r;
        run_op(1'b1, yas[i] & 255, x, yas[i] >> 8, lat);
        ref_div(yas[i] >> 8, yas[i] & 255, x, q, r);
        chk("R4/R5 sweep quotient", int'(a_out), q);
        chk("R4/R5 sweep remainder", int'(y_out), r);
      end
    end
    for (int x = 1; x < 128; x++) begin
      check_div(8'h5A, x, 2 * x, "R5 boundary");
      check_div(8'hFF, x, 2 * x - 1, "R4 boundary");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_mul();
    t_div_normal();
    t_div_wide();
    t_div_zero();
    t_latency();
    t_busy_ignore();
    t_vh_hold();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule